// File: doc/BRIEF.md
# Seven-Segment Scan Serializer

This block drives eight time-multiplexed seven-segment digits through an external chain of two serial-in, parallel-out shift registers that have an output storage latch. It receives a 32-bit value that holds eight hexadecimal nibbles. It runs from one system clock and uses no derived clocks. Two internal timing enables pace its work: a slot enable that moves the scan to the next digit, and a bit-phase counter that forms a shift clock on a plain output pin.

At the start of every slot, the block captures a 16-bit frame into a holding register. The upper byte of the frame is the active-low segment pattern of the current digit. The lower byte is a one-hot select for that digit. The frame leaves the block most significant bit first on a data pin. Each bit is clocked by a rising edge of the shift-clock pin. A latch pulse then moves the 16 bits to the register outputs. The display value may change at any time, and a frame that is already being sent is not disturbed.

Top module: `segscan_top`

## Requirements
- R1: Each frame is 16 bits wide. Bits [15:8] hold the segment pattern and bits [7:0] hold the digit select. In the select, bit n is 1 and every other bit is 0 when digit n is shown (digit 0 gives 8'b0000_0001).
- R2: A frame is sent most significant bit first, one bit per shift-clock rising edge, with exactly 16 rising edges per frame.
- R3: Digit n shows nibble n of `disp_value`, which is bits [4n+3:4n]. Digit 0 takes [3:0] and digit 7 takes [31:28].
- R4: Segments are active-low, and bit 7 (the decimal point) is always 1. The hex patterns are: 0→C0, 1→F9, 2→A4, 3→B0, 4→99, 5→92, 6→82, 7→F8, 8→80, 9→90, A→88, b→83, C→C6, d→A1, E→86, F→8E.
- R5: One frame is sent per scan slot of CLK_HZ/SCAN_HZ system clocks. The digit index rises by one per slot and wraps from 7 to 0. The first frame after reset is digit 0.
- R6: Each high or low half of the shift clock lasts HALF_CYC system clocks. The default of 2 gives one quarter of the system clock. The shift clock rests low between frames.
- R7: `ser_data` changes only while `ser_clk` is low, both in the cycle before the change and in the cycle of the change. It is therefore stable across every rising edge.
- R8: After the 16th rising edge, `ser_latch` is high for exactly 2*HALF_CYC system clocks while `ser_clk` stays low. It then returns low.
- R9: The frame is captured at the start of its slot. A change of `disp_value` while the frame is being sent does not affect that frame. The new value appears from the next slot on.
- R10: Reset is synchronous and active-low. While it is asserted, all three outputs are low. After it is released, the scan restarts at digit 0, even if the reset interrupted a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_value | input | 32 | Eight hex nibbles; nibble n is shown on digit n |
| ser_data | output | 1 | Serial frame data, MSB first |
| ser_clk | output | 1 | Shift clock for the external registers, idle low |
| ser_latch | output | 1 | Storage latch strobe, one shift-clock period wide |

## Verification
The embedded properties check the timing of the serial pins on every cycle. They check that data is stable while the shift clock is high, that each high phase of the shift clock has the right length, that the shift clock stays low during the latch pulse and at rest, that every loaded select is one-hot, and that the digit index wraps. The values of the frames can only be shown by the bench scenarios. These scenarios rebuild each shifted-in frame, compare it with a segment table the bench holds itself, follow the digit order across a full wrap, measure the spacing between slots, and change the display value or apply reset in the middle of a frame.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

   localparam int SEG_W = 8;
   localparam int NIB_W = 4;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_LATCH = 2'd2
   } shift_state_e;

   // Active-low glyphs; bit 7 (decimal point) kept at 1 (off).
   function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] h);
      logic [SEG_W-1:0] g;
      case (h)
         4'h0: g = 8'hC0;
         4'h1: g = 8'hF9;
         4'h2: g = 8'hA4;
         4'h3: g = 8'hB0;
         4'h4: g = 8'h99;
         4'h5: g = 8'h92;
         4'h6: g = 8'h82;
         4'h7: g = 8'hF8;
         4'h8: g = 8'h80;
         4'h9: g = 8'h90;
         4'hA: g = 8'h88;
         4'hB: g = 8'h83;
         4'hC: g = 8'hC6;
         4'hD: g = 8'hA1;
         4'hE: g = 8'h86;
         default: g = 8'h8E;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/segscan_tick.sv
module segscan_tick #(
   parameter int SLOT_CYC = 50_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_go
);

   localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

   generate
      if (SLOT_CYC < 2) begin : g_bad_slot
         $error("segscan_tick: SLOT_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + CW'(1);
   end

   // Slot starts in the first cycle after reset and every SLOT_CYC after.
   assign slot_go = rst_n && (cnt == '0);

   // R5
   slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_go |=> !slot_go);

endmodule

// File: rtl/segscan_frame.sv
module segscan_frame
   import segscan_pkg::*;
#(
   parameter int DIGITS = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      slot_go,
   input  logic [DIGITS*NIB_W-1:0]   value_i,
   output logic [SEG_W+DIGITS-1:0]   frame_o,
   output logic                      load_o
);

   localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

   generate
      if (DIGITS < 2) begin : g_bad_digits
         $error("segscan_frame: DIGITS must be at least 2");
      end
   endgenerate

   logic [NIB_W-1:0] nib [DIGITS];
   logic [IDX_W-1:0] idx;
   logic [DIGITS-1:0] sel;
   logic [SEG_W-1:0]  glyph;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_nib
         assign nib[g] = value_i[g*NIB_W +: NIB_W];
      end
   endgenerate

   always_comb begin
      sel = '0;
      sel[idx] = 1'b1;
      glyph = hex_glyph(nib[idx]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx     <= '0;
         frame_o <= {{SEG_W{1'b1}}, {DIGITS{1'b0}}};
         load_o  <= 1'b0;
      end else begin
         load_o <= slot_go;
         if (slot_go) begin
            frame_o <= {glyph, sel};
            idx     <= (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
         end
      end
   end

   // R1
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $onehot(frame_o[DIGITS-1:0]));

   // R5
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_go && idx == IDX_LAST) |=> (idx == '0));

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slot_go) |-> $stable(frame_o));

endmodule

// File: rtl/segscan_shifter.sv
module segscan_shifter
   import segscan_pkg::*;
#(
   parameter int FRAME_W  = 16,
   parameter int HALF_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               ser_data,
   output logic               ser_clk,
   output logic               ser_latch
);

   localparam int PER = 2 * HALF_CYC;
   localparam int PW  = $clog2(PER);
   localparam int BW  = $clog2(FRAME_W);
   localparam logic [PW-1:0] PH_RISE = PW'(HALF_CYC - 1);
   localparam logic [PW-1:0] PH_END  = PW'(PER - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

   generate
      if (HALF_CYC < 2) begin : g_bad_half
         $error("segscan_shifter: HALF_CYC must be at least 2");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("segscan_shifter: FRAME_W must be at least 2");
      end
   endgenerate

   shift_state_e     state;
   logic [PW-1:0]    ph;
   logic [BW-1:0]    bitc;
   logic [FRAME_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SH_IDLE;
         ph        <= '0;
         bitc      <= '0;
         shreg     <= '0;
         ser_data  <= 1'b0;
         ser_clk   <= 1'b0;
         ser_latch <= 1'b0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (load_i) begin
                  state <= SH_SHIFT;
                  shreg <= frame_i;
                  ph    <= '0;
                  bitc  <= '0;
               end
            end
            SH_SHIFT: begin
               ph <= (ph == PH_END) ? '0 : ph + PW'(1);
               // Present the next bit one cycle into the low phase.
               if (ph == '0)      ser_data <= shreg[FRAME_W-1];
               if (ph == PH_RISE) ser_clk  <= 1'b1;
               if (ph == PH_END) begin
                  ser_clk <= 1'b0;
                  shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                  if (bitc == BIT_LAST) begin
                     state     <= SH_LATCH;
                     ser_latch <= 1'b1;
                  end else begin
                     bitc <= bitc + BW'(1);
                  end
               end
            end
            SH_LATCH: begin
               ph <= (ph == PH_END) ? '0 : ph + PW'(1);
               if (ph == PH_END) begin
                  ser_latch <= 1'b0;
                  ser_data  <= 1'b0;
                  state     <= SH_IDLE;
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   // Checker-side run counter for the high phase of the shift clock.
   logic [PW:0] hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n)       hi_run <= '0;
      else if (ser_clk) hi_run <= hi_run + (PW+1)'(1);
      else              hi_run <= '0;
   end

   // R7
   data_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_data != $past(ser_data)) |-> (!ser_clk && !$past(ser_clk)));

   // R8
   latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> !ser_clk);

   // R8
   latch_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_latch) |=> ser_latch);

   // R6
   idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE) |-> !ser_clk);

   // R6
   clk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> (hi_run < (PW+1)'(HALF_CYC)));

endmodule

// File: rtl/segscan_top.sv
module segscan_top
   import segscan_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int SCAN_HZ  = 1_000,
   parameter int DIGITS   = 8,
   parameter int HALF_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DIGITS*NIB_W-1:0] disp_value,
   output logic                    ser_data,
   output logic                    ser_clk,
   output logic                    ser_latch
);

   localparam int SLOT_CYC = CLK_HZ / SCAN_HZ;
   localparam int FRAME_W  = SEG_W + DIGITS;
   localparam int FRAME_CYC = 2 * HALF_CYC * (FRAME_W + 1) + 2;

   generate
      if (SLOT_CYC < FRAME_CYC) begin : g_bad_rate
         $error("segscan_top: scan slot shorter than one serialized frame");
      end
   endgenerate

   logic               slot_go;
   logic               load;
   logic [FRAME_W-1:0] frame;

   segscan_tick #(.SLOT_CYC(SLOT_CYC)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_go (slot_go)
   );

   segscan_frame #(.DIGITS(DIGITS)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_go (slot_go),
      .value_i (disp_value),
      .frame_o (frame),
      .load_o  (load)
   );

   segscan_shifter #(.FRAME_W(FRAME_W), .HALF_CYC(HALF_CYC)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .frame_i   (frame),
      .ser_data  (ser_data),
      .ser_clk   (ser_clk),
      .ser_latch (ser_latch)
   );

endmodule

// File: tb/sim_segscan_top.sv
`timescale 1ns/1ps
module sim_segscan_top;

   localparam int SLOT = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] disp_value = '0;
   logic        ser_data, ser_clk, ser_latch;

   int n_chk = 0;
   int n_err = 0;

   segscan_top #(.CLK_HZ(100_000), .SCAN_HZ(1_000), .DIGITS(8), .HALF_CYC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .disp_value(disp_value),
      .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch)
   );

   always #4 clk = ~clk;

   function automatic logic [7:0] glyph_ref(input logic [3:0] h);
      logic [7:0] t [16] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82, 8'hF8,
                              8'h80, 8'h90, 8'h88, 8'h83, 8'hC6, 8'hA1, 8'h86, 8'h8E};
      return t[h];
   endfunction

   function automatic logic [15:0] frame_ref(input logic [31:0] v, input int k);
      logic [7:0] s;
      s = 8'h01 << k;
      return {glyph_ref(v[4*k +: 4]), s};
   endfunction

   // Pin monitor, sampled on the falling edge of the system clock.
   logic [15:0] fq [$];
   int          nq [$];
   longint      lt [$];
   longint      cyc = 0;
   logic [15:0] sh = '0;
   int nb = 0, chi = 0, lhi = 0;
   int dviol = 0, cbad = 0, lbad = 0, lcv = 0;
   logic pclk = 0, pdat = 0, plat = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (!rst_n) begin
         nb = 0; chi = 0; lhi = 0; pclk = 0; pdat = 0; plat = 0;
         fq.delete(); nq.delete(); lt.delete();
      end else begin
         if (ser_clk && !pclk) begin sh = {sh[14:0], ser_data}; nb++; end
         if (ser_data != pdat && (ser_clk || pclk)) dviol++;
         if (ser_clk) chi++;
         else if (pclk) begin if (chi != 2) cbad++; chi = 0; end
         if (ser_latch) lhi++;
         else if (plat) begin if (lhi != 4) lbad++; lhi = 0; end
         if (ser_latch && ser_clk) lcv++;
         if (ser_latch && !plat) begin
            fq.push_back(sh); nq.push_back(nb); lt.push_back(cyc); nb = 0;
         end
         pclk = ser_clk; pdat = ser_data; plat = ser_latch;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic get_frame(output logic [15:0] f, output int n);
      while (fq.size() == 0) @(negedge clk);
      f = fq.pop_front();
      n = nq.pop_front();
   endtask

   task automatic do_reset(input logic [31:0] v);
      @(negedge clk);
      rst_n = 1'b0;
      disp_value = v;
      repeat (4) @(negedge clk);
      chk("R10 outputs low in reset", {29'd0, ser_data, ser_clk, ser_latch}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_pattern(input logic [31:0] v, input int frames);
      logic [15:0] f;
      int n;
      do_reset(v);
      for (int i = 0; i < frames; i++) begin
         get_frame(f, n);
         chk("R1 R3 R4 R5 frame content", {16'd0, f}, {16'd0, frame_ref(v, i % 8)});
         chk("R2 bits per frame", n, 16);
      end
   endtask

   task automatic t_spacing;
      logic [15:0] f;
      int n;
      longint t0;
      do_reset(32'h1234_5678);
      get_frame(f, n);
      t0 = lt.size() > 0 ? lt[lt.size()-1] : 0;
      // Latch time of the frame just popped is the first entry recorded.
      while (lt.size() < 4) @(negedge clk);
      for (int i = 1; i < 4; i++)
         chk("R5 slot spacing", 32'(lt[i] - lt[i-1]), SLOT);
      chk("R5 first digit after reset", {16'd0, f}, {16'd0, frame_ref(32'h1234_5678, 0)});
      repeat (10) @(negedge clk);
      chk("R6 idle shift clock and data low", {30'd0, ser_clk, ser_data}, 32'd0);
      if (t0 < 0) n_err++;
   endtask

   task automatic t_midframe_change;
      logic [15:0] f;
      int n;
      do_reset(32'hA5A5_A5A5);
      while (nb < 4) @(negedge clk);
      disp_value = 32'h0F0F_0F0F;
      get_frame(f, n);
      chk("R9 frame in flight keeps old value", {16'd0, f}, {16'd0, frame_ref(32'hA5A5_A5A5, 0)});
      get_frame(f, n);
      chk("R9 next slot takes new value", {16'd0, f}, {16'd0, frame_ref(32'h0F0F_0F0F, 1)});
   endtask

   task automatic t_reset_midframe;
      logic [15:0] f;
      int n;
      do_reset(32'h8765_4321);
      get_frame(f, n);
      get_frame(f, n);
      while (nb < 5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 sync reset clears pins", {29'd0, ser_data, ser_clk, ser_latch}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      get_frame(f, n);
      chk("R10 scan restarts at digit 0", {16'd0, f}, {16'd0, frame_ref(32'h8765_4321, 0)});
      chk("R2 full frame after reset", n, 16);
   endtask

   task automatic t_pin_timing;
      chk("R7 data changed while shift clock high", dviol, 0);
      chk("R6 shift clock high phase length", cbad, 0);
      chk("R8 latch pulse length", lbad, 0);
      chk("R8 shift clock low during latch", lcv, 0);
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      t_pattern(32'h1234_5678, 9);
      t_pattern(32'h89AB_CDEF, 8);
      t_pattern(32'h0000_FFFF, 8);
      t_spacing();
      t_midframe_change();
      t_reset_midframe();
      t_pin_timing();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule